// File: doc/BRIEF.md
# Speculative Multi-Version Block Buffer

This block sits between a first-level and a second-level cache. It holds older and speculative copies of cache blocks so that stores made under speculation can be undone. Storage is split into one bank per write version. Each bank keeps its blocks in arrival order, with a head pointer and a tail pointer. At most one valid copy of an address lives in any one bank, but the same address may sit in several banks at once.

The banks are aged by a circular oldest-bank pointer. A bank's age distance is (bank − oldest) mod 4, and a larger distance means a newer version. A register also tracks the bank of the most recently committed version.

The first-level side inserts blocks and asks for the newest written copy. The second-level side has several jobs:
- draining committed blocks from the oldest bank;
- asking for the newest committed copy;
- purging or cleaning every copy of an address;
- committing one whole version, or squashing a version together with every newer one.

Every command takes one clock. Results and status are registered and appear on the outputs in the cycle after the command.

Top module: `spec_version_buf`

## Requirements
- R1: After reset every bank is empty. The oldest-bank pointer and the committed-bank register are both 0, bank 0 is non-speculative and banks 1–3 are speculative. Every output is 0.
- R2: An L1 insert (l1_cmd_i = 1) with l1_sf_i = 1 stores the block in bank l1_wv_i. Bank index = write version, in binary. Status is 1 the next cycle.
- R3: An insert with l1_sf_i = 0 ignores l1_wv_i and targets the most recently committed bank. Any insert that finds a valid copy of the same address in its target bank overwrites that copy in place. No new slot is used, and status is 1.
- R4: An insert whose target bank holds 4 entries, none of them a valid copy of the address, is refused with status 0 and changes nothing.
- R5: L1 find (l1_cmd_i = 2) returns the hit from the bank with the largest age distance. The response carries valid = 1, the dirty bit, write version = bank index, the read set, speculative flag = that bank's flag, the data, and status 1. A miss returns status 0 with all fields 0. Cycles that carry no L1 lookup response show all L1 fields at 0.
- R6: L2 find (l2_cmd_i = 3) considers only non-speculative banks and returns the newest hit's address, valid, dirty bit and data with status 1. A miss gives status 0 with all fields 0. L2 fields are 0 unless the command is a drain or a find.
- R7: Drain (l2_cmd_i = 2) works on the oldest bank.
  - If that bank is speculative, nothing changes.
  - If it is non-empty, its head entry is invalidated and the head advances. When that entry was valid, its address, dirty bit and data appear with valid = 1 and status 1; otherwise status is 0.
- R8: A drain that finds the oldest bank empty, and that bank not the committed bank, advances the oldest pointer by one mod 4. The retired bank becomes speculative. Status is 0.
- R9: Remove-all (l2_cmd_i = 1) clears the valid bit of every matching entry in every bank. Status is 1 if any valid match existed.
- R10: Clean-all (l2_cmd_i = 4) clears the dirty bit of every valid match in every bank. Status is 1 if any match existed.
- R11: Commit (l2_cmd_i = 5) clears the speculative flag of bank l2_vn_i and makes it the committed bank. Status is 1.
- R12: Squash (l2_cmd_i = 6) empties bank l2_vn_i and every bank with a larger age distance: all entries are invalidated and the head and tail pointers are reset. Status is 1.
- R13: A non-zero L2 command takes the cycle. An L1 command issued in the same cycle has no effect, and its status is 0. Codes L1 = 3 and L2 = 7 are no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_cmd_i | input | 2 | L1 command: 0 no-op, 1 insert, 2 find newest written |
| l1_addr_i | input | 8 | L1 block address |
| l1_valid_i | input | 1 | Valid bit of inserted block |
| l1_dirty_i | input | 1 | Dirty bit of inserted block |
| l1_wv_i | input | 2 | Write version of inserted block |
| l1_rvs_i | input | 4 | Read version set of inserted block |
| l1_sf_i | input | 1 | Speculative flag of inserted block |
| l1_data_i | input | 8 | Data of inserted block |
| l1_valid_o | output | 1 | Lookup: valid bit |
| l1_dirty_o | output | 1 | Lookup: dirty bit |
| l1_wv_o | output | 2 | Lookup: write version (bank) |
| l1_rvs_o | output | 4 | Lookup: read version set |
| l1_sf_o | output | 1 | Lookup: speculative flag of the bank |
| l1_data_o | output | 8 | Lookup: data |
| l1_status_o | output | 1 | 1 OK, 0 refused or miss |
| l2_cmd_i | input | 3 | L2 command: 0 no-op, 1 remove-all, 2 drain, 3 find committed, 4 clean-all, 5 commit, 6 squash |
| l2_vn_i | input | 2 | Version operand for commit and squash |
| l2_addr_i | input | 8 | L2 block address |
| l2_addr_o | output | 8 | Address of drained or found block |
| l2_valid_o | output | 1 | Drained or found block is valid |
| l2_dirty_o | output | 1 | Dirty bit of drained or found block |
| l2_data_o | output | 8 | Data of drained or found block |
| l2_status_o | output | 1 | 1 OK, 0 miss or nothing drained |

## Verification
The bench targets these corner cases:
- **Newest-hit selection across wrap.** Once the oldest pointer has moved past bank 0, a find must pick by age distance rather than by bank index. A design that ranked by index would return an older version.
- **Full-bank insert.** A full bank must refuse a new address but still accept an overwrite of an address it already holds. Getting this wrong either loses data or wrongly stalls.
- **Drain edge cases.** Draining a head entry that was already purged must advance the head without reporting a block. Draining an empty oldest bank must retire it only when it is not the committed bank; otherwise the committed version would be discarded or the drain would stall forever.
- **Squash wrapping around the age order.** A squash must wrap with the age order. Requests that collide across both ports must leave the L1 side untouched.

// File: rtl/vb_pkg.sv
package vb_pkg;
  parameter int NBANK = 4;
  parameter int DEPTH = 4;
  parameter int AW    = 8;
  parameter int DW    = 8;
  parameter int RW    = 4;
  localparam int BW   = $clog2(NBANK);

  localparam logic [1:0] L1_INS    = 2'd1;
  localparam logic [1:0] L1_FIND_W = 2'd2;

  localparam logic [2:0] L2_PURGE  = 3'd1;
  localparam logic [2:0] L2_DRAIN  = 3'd2;
  localparam logic [2:0] L2_FIND_C = 3'd3;
  localparam logic [2:0] L2_CLEAN  = 3'd4;
  localparam logic [2:0] L2_COMMIT = 3'd5;
  localparam logic [2:0] L2_SQUASH = 3'd6;

  typedef struct packed {
    logic          v;
    logic [AW-1:0] a;
    logic          d;
    logic [RW-1:0] r;
    logic [DW-1:0] dat;
  } ent_t;

  typedef struct packed {
    logic          valid;
    logic          dirty;
    logic [BW-1:0] wv;
    logic [RW-1:0] rvs;
    logic          sf;
    logic [DW-1:0] data;
    logic          status;
  } l1_rsp_t;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          valid;
    logic          dirty;
    logic [DW-1:0] data;
    logic          status;
  } l2_rsp_t;

  // distance from the oldest bank; larger is newer
  function automatic logic [BW-1:0] age_of(logic [BW-1:0] b, logic [BW-1:0] o);
    return b - o;
  endfunction
endpackage

// File: rtl/vb_bank.sv
module vb_bank
  import vb_pkg::*;
#(
  parameter int DEP = DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] key_i,
  input  logic          ins_en_i,
  input  ent_t          ins_ent_i,
  input  logic          clr_v_i,
  input  logic          clr_d_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          hit_o,
  output ent_t          hit_ent_o,
  output logic          head_v_o,
  output logic [AW-1:0] head_a_o,
  output logic          head_d_o,
  output logic [DW-1:0] head_dat_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int PW = $clog2(DEP);

  ent_t          mem_q [DEP];
  logic [PW-1:0] hd_q, tl_q;
  logic [PW:0]   cnt_q;
  logic [DEP-1:0] match;
  logic [PW-1:0] hidx;

  always_comb begin
    hidx = '0;
    for (int i = 0; i < DEP; i++) begin
      match[i] = mem_q[i].v && (mem_q[i].a == key_i);
      if (match[i]) hidx = i[PW-1:0];
    end
  end

  assign hit_o      = |match;
  assign hit_ent_o  = mem_q[hidx];
  assign head_v_o   = mem_q[hd_q].v;
  assign head_a_o   = mem_q[hd_q].a;
  assign head_d_o   = mem_q[hd_q].d;
  assign head_dat_o = mem_q[hd_q].dat;
  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == DEP[PW:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEP; i++) mem_q[i] <= '0;
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEP; i++) mem_q[i].v <= 1'b0;
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (ins_en_i) begin
        if (hit_o) begin
          mem_q[hidx] <= ins_ent_i;
        end else if (!full_o) begin
          mem_q[tl_q] <= ins_ent_i;
          tl_q  <= tl_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (clr_v_i)
        for (int i = 0; i < DEP; i++) if (match[i]) mem_q[i].v <= 1'b0;
      if (clr_d_i)
        for (int i = 0; i < DEP; i++) if (match[i]) mem_q[i].d <= 1'b0;
      if (pop_i) begin
        mem_q[hd_q].v <= 1'b0;
        hd_q  <= hd_q + 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vb_pick.sv
module vb_pick #(
  parameter int NB = 4,
  parameter int BW = $clog2(NB)
) (
  input  logic [NB-1:0] cand_i,
  input  logic [BW-1:0] old_i,
  output logic          found_o,
  output logic [BW-1:0] sel_o
);
  logic [BW-1:0] b;
  // walk oldest to newest; last candidate wins
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    b       = '0;
    for (int k = 0; k < NB; k++) begin
      b = old_i + k[BW-1:0];
      if (cand_i[b]) begin
        found_o = 1'b1;
        sel_o   = b;
      end
    end
  end
endmodule

// File: rtl/spec_version_buf.sv
module spec_version_buf
  import vb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    l1_cmd_i,
  input  logic [AW-1:0] l1_addr_i,
  input  logic          l1_valid_i,
  input  logic          l1_dirty_i,
  input  logic [BW-1:0] l1_wv_i,
  input  logic [RW-1:0] l1_rvs_i,
  input  logic          l1_sf_i,
  input  logic [DW-1:0] l1_data_i,
  output logic          l1_valid_o,
  output logic          l1_dirty_o,
  output logic [BW-1:0] l1_wv_o,
  output logic [RW-1:0] l1_rvs_o,
  output logic          l1_sf_o,
  output logic [DW-1:0] l1_data_o,
  output logic          l1_status_o,
  input  logic [2:0]    l2_cmd_i,
  input  logic [BW-1:0] l2_vn_i,
  input  logic [AW-1:0] l2_addr_i,
  output logic [AW-1:0] l2_addr_o,
  output logic          l2_valid_o,
  output logic          l2_dirty_o,
  output logic [DW-1:0] l2_data_o,
  output logic          l2_status_o
);
  logic [BW-1:0]    oldest_q, mrc_q;
  logic [NBANK-1:0] sf_q;
  l1_rsp_t          l1_q, l1_n;
  l2_rsp_t          l2_q, l2_n;

  logic             l2_act, ins_req, find_w;
  logic [BW-1:0]    ins_bank;
  logic [AW-1:0]    key;
  ent_t             ins_ent;
  logic             drain_cmd, drain_go, retire;

  logic [NBANK-1:0] hit, full, empty, head_v, head_d;
  ent_t             hit_ent  [NBANK];
  logic [AW-1:0]    head_a   [NBANK];
  logic [DW-1:0]    head_dat [NBANK];
  logic             fw_found, fc_found;
  logic [BW-1:0]    fw_sel, fc_sel;

  assign l2_act    = (l2_cmd_i != '0);
  assign ins_req   = !l2_act && (l1_cmd_i == L1_INS);
  assign find_w    = !l2_act && (l1_cmd_i == L1_FIND_W);
  assign ins_bank  = l1_sf_i ? l1_wv_i : mrc_q;
  assign key       = l2_act ? l2_addr_i : l1_addr_i;
  assign ins_ent   = '{v: l1_valid_i, a: l1_addr_i, d: l1_dirty_i, r: l1_rvs_i, dat: l1_data_i};
  assign drain_cmd = (l2_cmd_i == L2_DRAIN) && !sf_q[oldest_q];
  assign drain_go  = drain_cmd && !empty[oldest_q];
  assign retire    = drain_cmd && empty[oldest_q] && (oldest_q != mrc_q);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    vb_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .key_i      (key),
      .ins_en_i   (ins_req && (ins_bank == BW'(g))),
      .ins_ent_i  (ins_ent),
      .clr_v_i    (l2_cmd_i == L2_PURGE),
      .clr_d_i    (l2_cmd_i == L2_CLEAN),
      .pop_i      (drain_go && (oldest_q == BW'(g))),
      .flush_i    ((l2_cmd_i == L2_SQUASH) &&
                   (age_of(BW'(g), oldest_q) >= age_of(l2_vn_i, oldest_q))),
      .hit_o      (hit[g]),
      .hit_ent_o  (hit_ent[g]),
      .head_v_o   (head_v[g]),
      .head_a_o   (head_a[g]),
      .head_d_o   (head_d[g]),
      .head_dat_o (head_dat[g]),
      .empty_o    (empty[g]),
      .full_o     (full[g])
    );
  end

  vb_pick #(.NB(NBANK)) u_pick_w (
    .cand_i (hit), .old_i (oldest_q), .found_o (fw_found), .sel_o (fw_sel)
  );
  vb_pick #(.NB(NBANK)) u_pick_c (
    .cand_i (hit & ~sf_q), .old_i (oldest_q), .found_o (fc_found), .sel_o (fc_sel)
  );

  always_comb begin
    l1_n = '0;
    l2_n = '0;
    if (ins_req) l1_n.status = hit[ins_bank] || !full[ins_bank];
    if (find_w && fw_found) begin
      l1_n.valid  = hit_ent[fw_sel].v;
      l1_n.dirty  = hit_ent[fw_sel].d;
      l1_n.wv     = fw_sel;
      l1_n.rvs    = hit_ent[fw_sel].r;
      l1_n.sf     = sf_q[fw_sel];
      l1_n.data   = hit_ent[fw_sel].dat;
      l1_n.status = 1'b1;
    end
    case (l2_cmd_i)
      L2_PURGE, L2_CLEAN:   l2_n.status = |hit;
      L2_COMMIT, L2_SQUASH: l2_n.status = 1'b1;
      L2_DRAIN:
        if (drain_go && head_v[oldest_q]) begin
          l2_n.addr   = head_a[oldest_q];
          l2_n.valid  = 1'b1;
          l2_n.dirty  = head_d[oldest_q];
          l2_n.data   = head_dat[oldest_q];
          l2_n.status = 1'b1;
        end
      L2_FIND_C:
        if (fc_found) begin
          l2_n.addr   = hit_ent[fc_sel].a;
          l2_n.valid  = hit_ent[fc_sel].v;
          l2_n.dirty  = hit_ent[fc_sel].d;
          l2_n.data   = hit_ent[fc_sel].dat;
          l2_n.status = 1'b1;
        end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oldest_q <= '0;
      mrc_q    <= '0;
      sf_q     <= {{(NBANK-1){1'b1}}, 1'b0};
      l1_q     <= '0;
      l2_q     <= '0;
    end else begin
      l1_q <= l1_n;
      l2_q <= l2_n;
      if (l2_cmd_i == L2_COMMIT) begin
        sf_q[l2_vn_i] <= 1'b0;
        mrc_q         <= l2_vn_i;
      end
      if (retire) begin
        sf_q[oldest_q] <= 1'b1;
        oldest_q       <= oldest_q + 1'b1;
      end
    end
  end

  assign l1_valid_o  = l1_q.valid;
  assign l1_dirty_o  = l1_q.dirty;
  assign l1_wv_o     = l1_q.wv;
  assign l1_rvs_o    = l1_q.rvs;
  assign l1_sf_o     = l1_q.sf;
  assign l1_data_o   = l1_q.data;
  assign l1_status_o = l1_q.status;
  assign l2_addr_o   = l2_q.addr;
  assign l2_valid_o  = l2_q.valid;
  assign l2_dirty_o  = l2_q.dirty;
  assign l2_data_o   = l2_q.data;
  assign l2_status_o = l2_q.status;
endmodule

// File: rtl/vb_chk.sv
module vb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] l1_cmd_i,
  input logic [2:0] l2_cmd_i,
  input logic       l1_valid_o,
  input logic [7:0] l1_data_o,
  input logic       l1_status_o,
  input logic [7:0] l2_addr_o,
  input logic       l2_valid_o,
  input logic       l2_status_o
);
  // R13
  l2_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_cmd_i != 2'd0 && l2_cmd_i != 3'd0) |=> !l1_status_o);

  // R5
  find_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_cmd_i == 2'd2 && l2_cmd_i == 3'd0) |=> (l1_status_o == l1_valid_o));

  // R5
  l1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_cmd_i != 2'd2 || l2_cmd_i != 3'd0) |=> (!l1_valid_o && l1_data_o == 8'd0));

  // R6
  l2_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_cmd_i != 3'd2 && l2_cmd_i != 3'd3) |=> (!l2_valid_o && l2_addr_o == 8'd0));

  // R11
  commit_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_cmd_i == 3'd5) |=> l2_status_o);

  // R12
  squash_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_cmd_i == 3'd6) |=> l2_status_o);
endmodule

bind spec_version_buf vb_chk u_vb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .l1_cmd_i    (l1_cmd_i),
  .l2_cmd_i    (l2_cmd_i),
  .l1_valid_o  (l1_valid_o),
  .l1_data_o   (l1_data_o),
  .l1_status_o (l1_status_o),
  .l2_addr_o   (l2_addr_o),
  .l2_valid_o  (l2_valid_o),
  .l2_status_o (l2_status_o)
);

// File: tb/tb_spec_version_buf.sv
`timescale 1ns/1ps
module tb_spec_version_buf;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] l1_cmd = '0;
  logic [7:0] l1_addr = '0;
  logic       l1_v = 1'b0, l1_d = 1'b0, l1_s = 1'b0;
  logic [1:0] l1_w = '0;
  logic [3:0] l1_r = '0;
  logic [7:0] l1_dat = '0;
  logic [2:0] l2_cmd = '0;
  logic [1:0] l2_vn = '0;
  logic [7:0] l2_addr = '0;

  logic       o1_v, o1_d, o1_s, o1_st;
  logic [1:0] o1_w;
  logic [3:0] o1_r;
  logic [7:0] o1_dat;
  logic [7:0] o2_a, o2_dat;
  logic       o2_v, o2_d, o2_st;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spec_version_buf dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .l1_cmd_i(l1_cmd), .l1_addr_i(l1_addr), .l1_valid_i(l1_v), .l1_dirty_i(l1_d),
    .l1_wv_i(l1_w), .l1_rvs_i(l1_r), .l1_sf_i(l1_s), .l1_data_i(l1_dat),
    .l1_valid_o(o1_v), .l1_dirty_o(o1_d), .l1_wv_o(o1_w), .l1_rvs_o(o1_r),
    .l1_sf_o(o1_s), .l1_data_o(o1_dat), .l1_status_o(o1_st),
    .l2_cmd_i(l2_cmd), .l2_vn_i(l2_vn), .l2_addr_i(l2_addr),
    .l2_addr_o(o2_a), .l2_valid_o(o2_v), .l2_dirty_o(o2_d), .l2_data_o(o2_dat),
    .l2_status_o(o2_st)
  );

  typedef struct packed {
    logic v; logic [7:0] a; logic d; logic [3:0] r; logic [7:0] dat;
  } m_ent_t;

  m_ent_t mq[4][$];
  bit     msf[4];
  int     m_old, m_mrc;

  function automatic int mfind(int b, logic [7:0] a);
    for (int i = 0; i < mq[b].size(); i++)
      if (mq[b][i].v && mq[b][i].a == a) return i;
    return -1;
  endfunction

  function automatic logic [36:0] act_vec();
    return {o1_v, o1_d, o1_w, o1_r, o1_s, o1_dat, o1_st, o2_a, o2_v, o2_d, o2_dat, o2_st};
  endfunction

  task automatic chk(string req, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int c1, logic [7:0] a1, logic v1, logic d1, logic [1:0] w1,
                      logic [3:0] r1, logic s1, logic [7:0] t1,
                      int c2, logic [1:0] vn, logic [7:0] a2);
    logic e1v, e1d, e1s, e1st, e2v, e2d, e2st;
    logic [1:0] e1w;
    logic [3:0] e1r;
    logic [7:0] e1dat, e2a, e2dat;
    string tag;
    {e1v, e1d, e1s, e1st, e2v, e2d, e2st, e1w, e1r, e1dat, e2a, e2dat} = '0;
    tag = "R13";
    l1_cmd = c1[1:0]; l1_addr = a1; l1_v = v1; l1_d = d1; l1_w = w1; l1_r = r1;
    l1_s = s1; l1_dat = t1; l2_cmd = c2[2:0]; l2_vn = vn; l2_addr = a2;
    if (c2 != 0) begin
      if (c1 == 0) tag = "R6-L2";
      case (c2)
        1, 4: begin
          if (c1 == 0) tag = (c2 == 1) ? "R9" : "R10";
          for (int b = 0; b < 4; b++)
            for (int i = 0; i < mq[b].size(); i++)
              if (mq[b][i].v && mq[b][i].a == a2) begin
                e2st = 1'b1;
                if (c2 == 1) mq[b][i].v = 1'b0; else mq[b][i].d = 1'b0;
              end
        end
        2: begin
          if (c1 == 0) tag = "R7/R8";
          if (!msf[m_old]) begin
            if (mq[m_old].size() > 0) begin
              m_ent_t e = mq[m_old].pop_front();
              if (e.v) begin
                e2a = e.a; e2v = 1'b1; e2d = e.d; e2dat = e.dat; e2st = 1'b1;
              end
            end else if (m_old != m_mrc) begin
              msf[m_old] = 1'b1;
              m_old = (m_old + 1) % 4;
            end
          end
        end
        3: begin
          for (int k = 0; k < 4; k++) begin
            int b = (m_old + k) % 4;
            int ix = mfind(b, a2);
            if (!msf[b] && ix >= 0) begin
              e2a = a2; e2v = 1'b1; e2d = mq[b][ix].d; e2dat = mq[b][ix].dat; e2st = 1'b1;
            end
          end
        end
        5: begin
          if (c1 == 0) tag = "R11";
          msf[vn] = 1'b0; m_mrc = vn; e2st = 1'b1;
        end
        6: begin
          int d0 = (int'(vn) - m_old + 4) % 4;
          if (c1 == 0) tag = "R12";
          for (int b = 0; b < 4; b++)
            if ((b - m_old + 4) % 4 >= d0) mq[b].delete();
          e2st = 1'b1;
        end
        default: ;
      endcase
    end else if (c1 == 1) begin
      int tb = s1 ? int'(w1) : m_mrc;
      int ix = mfind(tb, a1);
      m_ent_t ne = '{v: v1, a: a1, d: d1, r: r1, dat: t1};
      tag = s1 ? "R2/R3/R4" : "R3/R4";
      if (ix >= 0) begin mq[tb][ix] = ne; e1st = 1'b1; end
      else if (mq[tb].size() < 4) begin mq[tb].push_back(ne); e1st = 1'b1; end
    end else if (c1 == 2) begin
      tag = "R5";
      for (int k = 0; k < 4; k++) begin
        int b = (m_old + k) % 4;
        int ix = mfind(b, a1);
        if (ix >= 0) begin
          e1v = 1'b1; e1d = mq[b][ix].d; e1w = b[1:0]; e1r = mq[b][ix].r;
          e1s = msf[b]; e1dat = mq[b][ix].dat; e1st = 1'b1;
        end
      end
    end else begin
      tag = "R13-nop";
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, act_vec(), {e1v, e1d, e1w, e1r, e1s, e1dat, e1st, e2a, e2v, e2d, e2dat, e2st});
  endtask

  task automatic ins(logic [7:0] a, logic s, logic [1:0] w, logic [7:0] t);
    step(1, a, 1'b1, 1'b1, w, 4'b0101, s, t, 0, 2'd0, 8'd0);
  endtask
  task automatic fw(logic [7:0] a);
    step(2, a, 0, 0, 0, 0, 0, 0, 0, 2'd0, 8'd0);
  endtask
  task automatic l2(int c, logic [1:0] vn, logic [7:0] a);
    step(0, 0, 0, 0, 0, 0, 0, 0, c, vn, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_old = 0; m_mrc = 0;
    msf[0] = 0; msf[1] = 1; msf[2] = 1; msf[3] = 1;
    repeat (3) @(negedge clk);
    chk("R1", act_vec(), '0);
    rst_ni = 1'b1;
    @(negedge clk);
    fw(8'h10);                        // R1: empty after reset
    l2(3, 0, 8'h10);                  // R1/R6 miss
    ins(8'h10, 1, 2'd1, 8'h11);       // R2 to bank 1
    ins(8'h10, 0, 2'd3, 8'h22);       // R3 to committed bank 0
    fw(8'h10);                        // R5 newest is bank 1
    l2(3, 0, 8'h10);                  // R6 committed copy
    ins(8'h10, 0, 2'd2, 8'h33);       // R3 overwrite in place
    l2(3, 0, 8'h10);
    for (int i = 0; i < 4; i++) ins(8'h20 + i[7:0], 1, 2'd2, 8'h40 + i[7:0]);
    ins(8'h24, 1, 2'd2, 8'h55);       // R4 refused
    fw(8'h24);
    ins(8'h21, 1, 2'd2, 8'h66);       // R3/R4 overwrite in full bank
    fw(8'h21);
    l2(4, 0, 8'h10);                  // R10
    fw(8'h10);
    l2(1, 0, 8'h10);                  // R9
    fw(8'h10);
    l2(1, 0, 8'h10);                  // R9 no match
    l2(5, 1, 0);                      // R11
    ins(8'h30, 0, 2'd0, 8'h77);       // R3 now into bank 1
    l2(3, 0, 8'h30);
    l2(2, 0, 0);                      // R7 head purged
    l2(2, 0, 0);                      // R8 retire bank 0
    l2(2, 0, 0);                      // R7 bank 1 head
    l2(2, 0, 0);
    ins(8'h50, 1, 2'd0, 8'h99);       // bank 0 is now newest
    fw(8'h50);
    fw(8'h21);
    l2(6, 2, 0);                      // R12 squash 2,3,0
    fw(8'h21);
    fw(8'h50);
    step(1, 8'h60, 1, 1, 2'd1, 4'hf, 1, 8'h12, 5, 2'd1, 8'h00);  // R13
    fw(8'h60);
    step(3, 8'h60, 0, 0, 0, 0, 0, 0, 0, 2'd0, 8'h00);            // R13 nop
    l2(7, 0, 0);                      // R13 nop
    for (int n = 0; n < 4000; n++) begin
      int c1 = $urandom_range(0, 3);
      int p = $urandom_range(0, 15);
      int c2 = (p < 8) ? 0 : (p == 15) ? 6 : $urandom_range(1, 7);
      logic [7:0] a = 8'($urandom_range(0, 5));
      step(c1, a, 1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
           8'($urandom), c2, 2'($urandom), 8'($urandom_range(0, 5)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule